// File: doc/BRIEF.md
# Register-Mapped Byte SPI Master

This block is a bus-attached SPI master that moves bytes between a host and one serial device. The host reaches six word registers through a simple single-cycle read/write bus: a control/status word, a data port, a clock divider, a transfer length word, an output-hold word and a DMA/threshold word. Bytes written to the data port enter a transmit FIFO. A mode-0 shifter takes them one at a time, sends them MSB first on MOSI and samples MISO. Each received byte goes into a receive FIFO, and the host drains that FIFO by reading the data port.

Software starts and stops traffic with a transfer-active bit in the control word. That bit also drives the active-low chip select directly. Either FIFO can be emptied by writing a one to its clear bit. Five status bits report FIFO occupancy and completion. A single level interrupt combines two of them under two enable bits. The DMA, serial-variant, length and hold fields are storage only. The bus has no back-pressure: a data-port write that cannot be taken is dropped, and a data-port read of an empty FIFO returns zero.

Register map (word offsets): 0x00 control/status, 0x04 data port, 0x08 divider, 0x0C length, 0x10 output hold, 0x14 DMA/threshold. Control bits: 3:0 stored config, 4 clear transmit FIFO (self-clearing, reads 0), 5 clear receive FIFO (self-clearing, reads 0), 7 transfer active (TA), 8 DMA enable (stored), 9 completion interrupt enable, 10 receive interrupt enable, 11 stored, 12 read enable (stored), 13 serial-variant enable (stored). Status bits (read-only): 16 DONE, 17 RXD, 18 TXD, 19 RXR, 20 RXF.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the registers read as follows: control 0x0004_1000, divider 0, length 0, output hold 1, DMA/threshold 0x3020_1020.
- R2: The divider and length registers keep bits 15:0 and the hold register keeps bits 3:0. The control word stores only bits 3:0, 7 and 13:8, and a control write leaves the read-only bits 20:16 unaffected. An access whose address has a nonzero bits 1:0, or lies at 0x18 or above, reads 0 and writes nothing.
- R3: RXD (bit 17) is 1 exactly when the receive FIFO holds at least one byte. RXF (bit 20) is 1 exactly when it holds FIFO_DEPTH bytes.
- R4: RXR (bit 19) is 1 exactly when TA is set and the receive FIFO holds at least 3/4 of FIFO_DEPTH bytes (12 for depth 16). A control write with TA low therefore clears it.
- R5: TXD (bit 18) is 1 exactly when the transmit FIFO is not full.
- R6: DONE (bit 16) is 1 exactly when TA is set, the transmit FIFO is empty and the shifter is idle.
- R7: irq is 1 exactly when (bit 9 and DONE) or (bit 10 and RXR).
- R8: A control write with bit 4 set empties the transmit FIFO, and a control write with bit 5 set empties the receive FIFO. Both bits read back 0. A byte already in the shifter still completes.
- R9: A write to the data port pushes wdata[7:0] into the transmit FIFO only if TA is set and the FIFO is not full. Any other data-port write is dropped.
- R10: The shifter starts a byte only when TA is set, the transmit FIFO is not empty and the receive FIFO has room. Every byte it sends pushes exactly one byte into the receive FIFO.
- R11: A data-port read returns the oldest received byte in bits 7:0 and pops it when RXD is 1. Otherwise it returns 0 and pops nothing.
- R12: Serial timing is mode 0. SCLK idles low. Each half period lasts H clocks, where H is the divider value latched at byte start, and 0 means 65536. A byte occupies 16·H clocks and is sent MSB first. MOSI changes only when SCLK falls, and MOSI is low while idle. spi_cs_n is the inverse of TA.
- R13: The received byte consists of the MISO values sampled at the eight rising SCLK edges, MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a data-port read pops at the clock edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during bus_rd, 0 otherwise |
| irq | output | 1 | Level interrupt |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with the default depth of 16 and a divider width of 16. It programs divider values of 1, 2 and 200 at run time, so it can fill both FIFOs to the brim, stall the shifter on a full receive FIFO and watch it resume after one read. The 200 setting keeps a byte in flight long enough to fill the transmit FIFO and to clear it mid-byte. A divider of 0 runs for a few thousand clocks before a reset aborts the byte, which shows the 65536 half period without the million-clock byte. MISO is looped back inverted from MOSI, so every received byte must equal the complement of the byte sent.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  // register selects, from byte address bits 4:2
  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_DATA = 3'd1;
  localparam logic [2:0] SEL_DIV  = 3'd2;
  localparam logic [2:0] SEL_LEN  = 3'd3;
  localparam logic [2:0] SEL_HOLD = 3'd4;
  localparam logic [2:0] SEL_DMA  = 3'd5;

  // control bit positions
  localparam int unsigned B_CLR_TX  = 4;
  localparam int unsigned B_CLR_RX  = 5;
  localparam int unsigned B_TA      = 7;
  localparam int unsigned B_IE_DONE = 9;
  localparam int unsigned B_IE_RX   = 10;
  localparam int unsigned B_STATUS  = 16;

  localparam logic [31:0] CTRL_WMASK = 32'h0000_3F8F;
  localparam logic [31:0] CTRL_RST   = 32'h0000_1000;
  localparam logic [31:0] DMA_RST    = 32'h3020_1020;

  // packed so that done lands on bit 16 and rxf on bit 20
  typedef struct packed {
    logic rxf;
    logic rxr;
    logic txd;
    logic rxd;
    logic done;
  } status_t;

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             push, pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = count < CNT_W'(DEPTH);
  assign out_valid = count != '0;
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clear) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  // R9: occupancy never runs past the depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned HALF_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [7:0]       start_data,
  input  logic             miso,
  output logic             done_valid,
  output logic [7:0]       done_data,
  output logic             busy,
  output logic             sclk,
  output logic             mosi
);

  logic [HALF_W-1:0] half_len_q, half_cnt;
  logic [3:0]        edge_cnt;
  logic [7:0]        shreg;
  logic              samp;
  logic              half_end;
  logic [HALF_W-1:0] half_len;

  assign half_len    = (div == '0) ? (HALF_W'(1) << DIV_W) : HALF_W'(div);
  assign start_ready = ~busy;
  assign half_end    = busy & (half_cnt == half_len_q - 1'b1);
  assign done_valid  = half_end & (edge_cnt == 4'd15);
  assign done_data   = {shreg[6:0], samp};
  assign mosi        = busy & shreg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      half_len_q <= HALF_W'(1);
      half_cnt   <= '0;
      edge_cnt   <= '0;
      shreg      <= '0;
      samp       <= 1'b0;
      sclk       <= 1'b0;
    end else if (!busy) begin
      if (start_valid) begin
        busy       <= 1'b1;
        shreg      <= start_data;
        half_cnt   <= '0;
        edge_cnt   <= '0;
        half_len_q <= half_len;
      end
    end else if (half_end) begin
      half_cnt <= '0;
      sclk     <= ~sclk;
      edge_cnt <= edge_cnt + 1'b1;
      if (!edge_cnt[0]) begin
        samp <= miso;
      end else begin
        shreg <= {shreg[6:0], samp};
        if (edge_cnt == 4'd15) busy <= 1'b0;
      end
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  // R12: no serial clock activity outside a byte
  p_idle_sclk_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R12: data out holds while the clock stays high
  p_mosi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_fm_regs.sv
module spi_fm_regs import spi_fm_pkg::*; #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned HOLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       sel,
  input  logic [31:0]      wdata,
  input  status_t          status,
  input  logic [7:0]       rx_head,
  output logic [31:0]      rdata,
  output logic             ta,
  output logic             ie_done,
  output logic             ie_rx,
  output logic             clr_tx,
  output logic             clr_rx,
  output logic [DIV_W-1:0] div
);

  logic [31:0]       ctrl_q, dma_q;
  logic [LEN_W-1:0]  len_q;
  logic [HOLD_W-1:0] hold_q;
  logic              wr_ctrl;

  assign wr_ctrl = wr_en & (sel == SEL_CTRL);
  assign clr_tx  = wr_ctrl & wdata[B_CLR_TX];
  assign clr_rx  = wr_ctrl & wdata[B_CLR_RX];
  assign ta      = ctrl_q[B_TA];
  assign ie_done = ctrl_q[B_IE_DONE];
  assign ie_rx   = ctrl_q[B_IE_RX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      div    <= '0;
      len_q  <= '0;
      hold_q <= HOLD_W'(1);
      dma_q  <= DMA_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: ctrl_q <= wdata & CTRL_WMASK;
        SEL_DIV:  div    <= wdata[DIV_W-1:0];
        SEL_LEN:  len_q  <= wdata[LEN_W-1:0];
        SEL_HOLD: hold_q <= wdata[HOLD_W-1:0];
        SEL_DMA:  dma_q  <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_CTRL: rdata = ctrl_q | (32'(status) << B_STATUS);
        SEL_DATA: rdata = status.rxd ? 32'(rx_head) : '0;
        SEL_DIV:  rdata = 32'(div);
        SEL_LEN:  rdata = 32'(len_q);
        SEL_HOLD: rdata = 32'(hold_q);
        SEL_DMA:  rdata = dma_q;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master import spi_fm_pkg::*; #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DIV_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);

  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned RX_THR = (FIFO_DEPTH * 3) / 4;

  logic [2:0]       sel;
  logic             sel_ok, reg_wr, reg_rd, data_wr, data_rd;
  logic             ta, ie_done, ie_rx, clr_tx, clr_rx;
  logic [DIV_W-1:0] div;
  status_t          status;

  logic             tx_in_ready, tx_out_valid, tx_pop_ready;
  logic [7:0]       tx_head;
  logic [CNT_W-1:0] tx_cnt;
  logic             rx_in_ready, rx_out_valid;
  logic [7:0]       rx_head;
  logic [CNT_W-1:0] rx_cnt;

  logic             eng_start, eng_ready, eng_done, eng_busy;
  logic [7:0]       eng_rx;

  assign sel     = bus_addr[4:2];
  assign sel_ok  = (bus_addr[1:0] == 2'b00) && (sel <= SEL_DMA);
  assign reg_wr  = bus_wr & sel_ok;
  assign reg_rd  = bus_rd & sel_ok;
  assign data_wr = reg_wr & (sel == SEL_DATA);
  assign data_rd = reg_rd & (sel == SEL_DATA);

  spi_fm_regs #(.DIV_W(DIV_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .sel     (sel),
    .wdata   (bus_wdata),
    .status  (status),
    .rx_head (rx_head),
    .rdata   (bus_rdata),
    .ta      (ta),
    .ie_done (ie_done),
    .ie_rx   (ie_rx),
    .clr_tx  (clr_tx),
    .clr_rx  (clr_rx),
    .div     (div)
  );

  spi_fm_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) tx_fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr_tx),
    .in_valid  (data_wr & ta),
    .in_ready  (tx_in_ready),
    .in_data   (bus_wdata[7:0]),
    .out_valid (tx_out_valid),
    .out_ready (tx_pop_ready),
    .out_data  (tx_head),
    .count     (tx_cnt)
  );

  spi_fm_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) rx_fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr_rx),
    .in_valid  (eng_done),
    .in_ready  (rx_in_ready),
    .in_data   (eng_rx),
    .out_valid (rx_out_valid),
    .out_ready (data_rd),
    .out_data  (rx_head),
    .count     (rx_cnt)
  );

  // a byte may only launch with room reserved for its reply
  assign eng_start    = ta & tx_out_valid & rx_in_ready;
  assign tx_pop_ready = ta & rx_in_ready & eng_ready;

  spi_fm_shifter #(.DIV_W(DIV_W)) shifter_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .div         (div),
    .start_valid (eng_start),
    .start_ready (eng_ready),
    .start_data  (tx_head),
    .miso        (spi_miso),
    .done_valid  (eng_done),
    .done_data   (eng_rx),
    .busy        (eng_busy),
    .sclk        (spi_sclk),
    .mosi        (spi_mosi)
  );

  always_comb begin
    status.rxd  = rx_out_valid;
    status.rxf  = ~rx_in_ready;
    status.txd  = tx_in_ready;
    status.rxr  = ta & (rx_cnt >= CNT_W'(RX_THR));
    status.done = ta & ~tx_out_valid & ~eng_busy;
  end

  assign irq      = (ie_done & status.done) | (ie_rx & status.rxr);
  assign spi_cs_n = ~ta;

  // R10: a finished byte always finds a free receive slot
  p_rx_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> rx_in_ready);

  // R10: the transmit FIFO is popped only into an idle shifter
  p_pop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_pop_ready) |-> !eng_busy);

  // R9: data writes with transfer-active low leave the transmit FIFO alone
  p_drop_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ta && !(tx_out_valid && tx_pop_ready) && !clr_tx)
      |=> tx_cnt == $past(tx_cnt));

endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int THR        = (DEPTH * 3) / 4;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        b_wr, b_rd;
  logic [4:0]  b_addr;
  logic [31:0] b_wdata;
  logic [31:0] rdata;
  logic        irq, sclk, mosi, miso, cs_n;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign miso = ~mosi;   // inverted loopback: reply is the complement

  spi_fifo_master #(.FIFO_DEPTH(DEPTH), .DIV_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata),
    .irq(irq), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
    .spi_cs_n(cs_n)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_ctrl, m_dma;
  logic [15:0] m_div, m_len;
  logic [3:0]  m_hold;
  logic [7:0]  m_tx[$];
  logic [7:0]  m_rx[$];
  bit          m_busy;
  int          m_left, m_half;
  logic [7:0]  m_cur;

  function automatic bit m_ta();   return m_ctrl[7]; endfunction
  function automatic bit m_done(); return m_ta() && m_tx.size() == 0 && !m_busy; endfunction
  function automatic bit m_rxr();  return m_ta() && m_rx.size() >= THR; endfunction

  function automatic logic [31:0] m_status();
    logic [4:0] s;
    s = {m_rx.size() == DEPTH, m_rxr(), m_tx.size() < DEPTH,
         m_rx.size() > 0, m_done()};
    return {11'b0, s, 16'b0};
  endfunction

  function automatic bit addr_ok(input logic [4:0] a);
    return a[1:0] == 2'b00 && a[4:2] <= 3'd5;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!b_rd || !addr_ok(b_addr)) return 32'h0;
    case (b_addr[4:2])
      3'd0: return m_ctrl | m_status();
      3'd1: return (m_rx.size() > 0) ? {24'h0, m_rx[0]} : 32'h0;
      3'd2: return {16'h0, m_div};
      3'd3: return {16'h0, m_len};
      3'd4: return {28'h0, m_hold};
      default: return m_dma;
    endcase
  endfunction

  function automatic bit exp_sclk();
    int el;
    if (!m_busy) return 1'b0;
    el = 16 * m_half - m_left;
    return ((el / m_half) % 2) == 1;
  endfunction

  function automatic bit exp_mosi();
    int el;
    if (!m_busy) return 1'b0;
    el = 16 * m_half - m_left;
    return m_cur[7 - el / (2 * m_half)];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h0000_1000; m_div = 0; m_len = 0; m_hold = 4'h1;
      m_dma = 32'h3020_1020;
      m_tx.delete(); m_rx.delete();
      m_busy = 0; m_left = 0; m_half = 1; m_cur = 0;
    end else begin
      bit ta0, go, ctx, crx, ok;
      int txn, rxn;
      ta0 = m_ta(); txn = m_tx.size(); rxn = m_rx.size();
      go  = !m_busy && ta0 && txn > 0 && rxn < DEPTH;
      ok  = addr_ok(b_addr);
      ctx = 0; crx = 0;
      if (b_rd && ok && b_addr[4:2] == 3'd1 && rxn > 0) void'(m_rx.pop_front());
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_rx.push_back(~m_cur); m_busy = 0; end
      end else if (go) begin
        m_cur = m_tx.pop_front(); m_busy = 1;
        m_half = (m_div == 0) ? 65536 : int'(m_div);
        m_left = 16 * m_half;
      end
      if (b_wr && ok) begin
        case (b_addr[4:2])
          3'd0: begin m_ctrl = b_wdata & 32'h0000_3F8F; ctx = b_wdata[4]; crx = b_wdata[5]; end
          3'd1: if (ta0 && txn < DEPTH) m_tx.push_back(b_wdata[7:0]);
          3'd2: m_div = b_wdata[15:0];
          3'd3: m_len = b_wdata[15:0];
          3'd4: m_hold = b_wdata[3:0];
          default: m_dma = b_wdata;
        endcase
      end
      if (ctx) m_tx.delete();
      if (crx) m_rx.delete();
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R7 irq", {31'b0, irq}, {31'b0, (m_ctrl[9] && m_done()) || (m_ctrl[10] && m_rxr())});
      chk("R12 cs_n", {31'b0, cs_n}, {31'b0, !m_ta()});
      chk("R12 sclk", {31'b0, sclk}, {31'b0, exp_sclk()});
      chk("R12 mosi", {31'b0, mosi}, {31'b0, exp_mosi()});
      if (b_rd) chk(cur_tag, rdata, exp_rdata());
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    b_wr = 1; b_addr = a; b_wdata = d; step(1); b_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    cur_tag = tag; b_rd = 1; b_addr = a; step(1); b_rd = 0;
  endtask

  // direct check against a hand-stated constant
  task automatic rd_const(input logic [4:0] a, input logic [31:0] exp, input string tag);
    b_rd = 1; b_addr = a; cur_tag = tag;
    @(negedge clk); chk(tag, rdata, exp);
    @(posedge clk); #1; b_rd = 0;
  endtask

  initial begin
    b_wr = 0; b_rd = 0; b_addr = 0; b_wdata = 0; rst_n = 0;
    step(3); rst_n = 1; cmp_on = 1;

    // reset values
    rd_const(5'h00, 32'h0004_1000, "R1 ctrl reset");
    rd_const(5'h08, 32'h0, "R1 div reset");
    rd_const(5'h0C, 32'h0, "R1 len reset");
    rd_const(5'h10, 32'h1, "R1 hold reset");
    rd_const(5'h14, 32'h3020_1020, "R1 dma reset");

    // widths, masks, bad addresses
    wr(5'h08, 32'hFFFF_ABCD); rd_const(5'h08, 32'h0000_ABCD, "R2 div width");
    wr(5'h0C, 32'h1234_5678); rd_const(5'h0C, 32'h0000_5678, "R2 len width");
    wr(5'h10, 32'hFFFF_FFFF); rd_const(5'h10, 32'h0000_000F, "R2 hold width");
    wr(5'h14, 32'hDEAD_BEEF); rd_const(5'h14, 32'hDEAD_BEEF, "R2 dma store");
    wr(5'h00, 32'hFFFF_FF4F); rd_const(5'h00, 32'h0004_3F0F, "R2 ctrl mask");
    wr(5'h18, 32'hFFFF_FFFF); rd_const(5'h18, 32'h0, "R2 hole");
    wr(5'h09, 32'h0000_0077); rd_const(5'h08, 32'h0000_ABCD, "R2 misaligned");
    rd_const(5'h1C, 32'h0, "R2 hole");

    // dropped write while inactive, then DONE with nothing queued
    wr(5'h00, 32'h0000_1000);
    wr(5'h08, 32'h2);
    wr(5'h04, 32'h55);
    wr(5'h00, 32'h0000_1080);
    step(40);
    rd(5'h00, "R9 R6 inactive write dropped");
    rd(5'h04, "R11 R9 nothing received");

    // basic transfer
    wr(5'h04, 32'hA5); wr(5'h04, 32'h3C);
    step(100);
    rd(5'h00, "R3 R6 after two bytes");
    rd(5'h04, "R13 R11 first reply");
    rd(5'h04, "R13 R11 second reply");
    rd(5'h04, "R11 empty read");

    // slow clock: fill the transmit FIFO, drop overflow, clear mid-byte
    wr(5'h08, 32'd200);
    wr(5'h00, 32'h0000_1480);
    for (int i = 0; i < DEPTH + 2; i++) wr(5'h04, 32'(i * 17 + 3));
    rd(5'h00, "R5 transmit full");
    wr(5'h00, 32'h0000_1490);
    rd(5'h00, "R8 R6 cleared while busy");
    step(3300);
    rd(5'h00, "R8 R6 byte completed");

    // fast clock: fill the receive FIFO and stall
    wr(5'h08, 32'd1);
    for (int i = 0; i < DEPTH; i++) wr(5'h04, 32'(8'hC0 + i));
    step(400);
    rd(5'h00, "R3 R4 R10 receive full stall");
    rd(5'h04, "R13 oldest reply");
    step(60);
    rd(5'h00, "R10 resumed after read");

    // TA low clears the threshold flag, then clear receive
    wr(5'h00, 32'h0000_1400);
    rd(5'h00, "R4 TA low");
    wr(5'h00, 32'h0000_14A0);
    rd(5'h00, "R8 R3 receive cleared");
    wr(5'h00, 32'h0000_1280);
    step(2);
    rd(5'h00, "R7 done interrupt");

    // divider zero: long half period, aborted by reset
    wr(5'h08, 32'd0);
    wr(5'h04, 32'h81);
    step(2000);
    rd(5'h00, "R12 divider zero still in byte");
    rst_n = 0; step(2); rst_n = 1;
    rd_const(5'h00, 32'h0004_1000, "R1 ctrl after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    failures++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule